// File: doc/BRIEF.md
# Parallel Multi-Channel SPI ADC Reader

This block reads a bank of serial-output analog-to-digital converters in lockstep. One sequencer produces a single chip-select and serial-clock timing pattern. Each channel then re-registers that pattern in its own output flip-flops, so every pin has a private driver that can be placed beside it. Each channel has its own serial data input, and its word is assembled in a shift register local to that channel. When a conversion finishes, all words are presented side by side, together with a one-cycle completion strobe.

After reset, a thermometer-code chain fills with ones at the rate of one bit per clock. Bit k of that chain holds channel k's output flip-flops in synchronous clear, so the channels come out of clear in order. While any bit of the chain is still zero, the start strobe has no effect. Serial clock idles low, and data is captured MSB first on the rising serial-clock edge.

Top module: `adc_par_reader`

## Requirements
- R1: After the synchronous reset is released, the release chain gains one set bit per clock. A start strobe sampled on any of the first 16 rising edges has no effect. A start sampled on edge 17 is accepted, and chip-select goes low on edge 18.
- R2: While a channel is held in clear, and at all times outside a transaction, its chip-select output is high and its serial-clock output is low. Serial clock is never high while chip-select is high.
- R3: A transaction drives chip-select low and then issues exactly DW serial-clock periods. Each period is CLK_DIV system clocks, low for the first half and high for the second. The first rising serial-clock edge comes CLK_DIV/2 clocks after chip-select falls.
- R4: Each channel k samples its own serial input on every rising serial-clock edge, MSB first. The DW bits form that channel's word, which appears on result bits [k*DW +: DW].
- R5: On the clock edge where chip-select returns high, done pulses high for exactly one cycle. On that same edge all result words update. The words then hold until the next done.
- R6: Chip-select stays high for at least GAP_SCLK serial-clock periods. A start sampled on any of the first GAP_SCLK*CLK_DIV - 1 edges after the done edge is ignored. A start sampled on edge GAP_SCLK*CLK_DIV after done is accepted.
- R7: A start strobe that arrives while a transaction is in progress is ignored, and no second transaction follows.
- R8: A reset during a transaction returns chip-select high and serial clock low on the next edge. It also clears the result words and done, and it restarts the staggered release of R1.
- R9: All chip-select outputs carry identical values in every cycle, and so do all serial-clock outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Conversion start request, sampled each clock |
| miso_i | input | NCH | Serial data from each converter, bit k is channel k |
| cs_n_o | output | NCH | Per-channel chip-select, active low |
| sclk_o | output | NCH | Per-channel serial clock, idle low |
| result_o | output | NCH*DW | Channel words, channel k at bits [k*DW +: DW] |
| done_o | output | 1 | One-cycle pulse when results update |

## Verification
Two things can land on the same clock edge: a start request, and the end of a period in which starts are locked out. One such period is the release fill after reset; the other is the enforced chip-select high time after done. The bench holds start high across each lockout and drops it one edge before the lockout ends, then checks that chip-select never falls. It then repeats the hold for one more edge and checks that chip-select stays high at the next sampling point and is low one cycle later. A start pulsed in the middle of a transaction is judged the same way, by watching that chip-select stays high after done.

// File: rtl/adc_rd_pkg.sv
// Shared types for the parallel SPI ADC reader.
package adc_rd_pkg;
    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_XFER = 2'd1,
        SQ_GAP  = 2'd2
    } sq_state_t;
endpackage

// File: rtl/adc_release_chain.sv
// Power-up release chain: a thermometer shift register that fills with ones,
// one bit per clock, after reset. Bit k releases channel k's output clear.
// Assumes NCH >= 2.
module adc_release_chain #(
    parameter int NCH = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    output logic [NCH-1:0] therm_o,
    output logic           ready_o
);
    logic [NCH-1:0] therm_q;

    // Shift a constant one in each clock; reset empties the chain.
    always_ff @(posedge clk) begin
        if (!rst_n) therm_q <= '0;
        else        therm_q <= {therm_q[NCH-2:0], 1'b1};
    end

    assign therm_o = therm_q;
    assign ready_o = &therm_q;
endmodule

// File: rtl/adc_seq.sv
// Shared transaction sequencer: one timing pattern for all channels.
// Produces registered chip-select, serial clock, a sample strobe aligned with
// the serial-clock rising cycle, and a done strobe aligned with chip-select
// rising. Assumes CLK_DIV is even and >= 2, GAP_SCLK >= 1.
module adc_seq
    import adc_rd_pkg::*;
#(
    parameter int DW       = 16,
    parameter int CLK_DIV  = 4,
    parameter int GAP_SCLK = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic ready_i,
    output logic cs_n_o,
    output logic sclk_o,
    output logic smp_o,
    output logic done_o
);
    localparam int HALF = CLK_DIV / 2;
    localparam int PW   = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
    localparam int BW   = (DW > 1) ? $clog2(DW) : 1;
    localparam int GAPC = GAP_SCLK * CLK_DIV;
    localparam int GW   = $clog2(GAPC + 1);

    sq_state_t     st_q;
    logic [PW-1:0] ph_q;
    logic [BW-1:0] bit_q;
    logic [GW-1:0] gap_q;

    // Transaction state machine with phase, bit and gap counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= SQ_IDLE;
            ph_q   <= '0;
            bit_q  <= '0;
            gap_q  <= '0;
            cs_n_o <= 1'b1;
            sclk_o <= 1'b0;
            smp_o  <= 1'b0;
            done_o <= 1'b0;
        end else begin
            smp_o  <= 1'b0;
            done_o <= 1'b0;
            unique case (st_q)
                SQ_IDLE: begin
                    if (start_i && ready_i) begin
                        st_q   <= SQ_XFER;
                        ph_q   <= '0;
                        bit_q  <= '0;
                        cs_n_o <= 1'b0;
                    end
                end
                SQ_XFER: begin
                    if (ph_q == PW'(CLK_DIV - 1)) begin
                        ph_q   <= '0;
                        sclk_o <= 1'b0;
                        if (bit_q == BW'(DW - 1)) begin
                            st_q   <= SQ_GAP;
                            gap_q  <= '0;
                            cs_n_o <= 1'b1;
                            done_o <= 1'b1;
                        end else begin
                            bit_q <= bit_q + 1'b1;
                        end
                    end else begin
                        ph_q <= ph_q + 1'b1;
                        if (ph_q == PW'(HALF - 1)) begin
                            sclk_o <= 1'b1;
                            smp_o  <= 1'b1;
                        end
                    end
                end
                SQ_GAP: begin
                    if (gap_q == GW'(GAPC - 1)) st_q  <= SQ_IDLE;
                    else                        gap_q <= gap_q + 1'b1;
                end
                default: st_q <= SQ_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/adc_lane.sv
// One converter channel: private chip-select and serial-clock output
// registers with a synchronous clear from the release chain, a capture
// shift register and a result holding register.
// Assumes smp_i is high in the cycle before the serial-clock output rises.
module adc_lane #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en_i,
    input  logic          cs_n_i,
    input  logic          sclk_i,
    input  logic          smp_i,
    input  logic          done_i,
    input  logic          miso_i,
    output logic          cs_n_o,
    output logic          sclk_o,
    output logic [DW-1:0] word_o
);
    logic [DW-1:0] sh_q;

    // Pin-side output registers, held idle while the channel is in clear.
    always_ff @(posedge clk) begin
        if (!rst_n || !en_i) begin
            cs_n_o <= 1'b1;
            sclk_o <= 1'b0;
        end else begin
            cs_n_o <= cs_n_i;
            sclk_o <= sclk_i;
        end
    end

    // Capture one bit, MSB first, on the edge the serial clock rises.
    always_ff @(posedge clk) begin
        if (!rst_n)     sh_q <= '0;
        else if (smp_i) sh_q <= {sh_q[DW-2:0], miso_i};
    end

    // Hold the completed word until the next transaction ends.
    always_ff @(posedge clk) begin
        if (!rst_n)      word_o <= '0;
        else if (done_i) word_o <= sh_q;
    end
endmodule

// File: rtl/adc_par_reader.sv
// Top: parallel SPI ADC reader. One sequencer feeds NCH lanes, each with its
// own output registers released in turn by the thermometer chain.
// Assumes DW >= 2, NCH >= 2, CLK_DIV even and >= 2.
module adc_par_reader #(
    parameter int NCH      = 16,
    parameter int DW       = 16,
    parameter int CLK_DIV  = 4,
    parameter int GAP_SCLK = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [NCH-1:0]    miso_i,
    output logic [NCH-1:0]    cs_n_o,
    output logic [NCH-1:0]    sclk_o,
    output logic [NCH*DW-1:0] result_o,
    output logic              done_o
);
    logic [NCH-1:0] therm;
    logic           rel_ready;
    logic           seq_cs_n, seq_sclk, seq_smp, seq_done;

    adc_release_chain #(.NCH(NCH)) u_rel (
        .clk(clk), .rst_n(rst_n), .therm_o(therm), .ready_o(rel_ready)
    );

    adc_seq #(.DW(DW), .CLK_DIV(CLK_DIV), .GAP_SCLK(GAP_SCLK)) u_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .ready_i(rel_ready),
        .cs_n_o(seq_cs_n), .sclk_o(seq_sclk), .smp_o(seq_smp), .done_o(seq_done)
    );

    for (genvar k = 0; k < NCH; k++) begin : g_lane
        adc_lane #(.DW(DW)) u_lane (
            .clk(clk), .rst_n(rst_n), .en_i(therm[k]),
            .cs_n_i(seq_cs_n), .sclk_i(seq_sclk), .smp_i(seq_smp),
            .done_i(seq_done), .miso_i(miso_i[k]),
            .cs_n_o(cs_n_o[k]), .sclk_o(sclk_o[k]),
            .word_o(result_o[k*DW +: DW])
        );
    end

    // Align the done strobe with the lane output registers.
    always_ff @(posedge clk) begin
        if (!rst_n) done_o <= 1'b0;
        else        done_o <= seq_done;
    end
endmodule

// File: rtl/adc_reader_chk.sv
// Property checker for adc_par_reader, attached by bind.
module adc_reader_chk #(
    parameter int NCH  = 16,
    parameter int GAPC = 8
) (
    input logic           clk,
    input logic           rst_n,
    input logic           ready,
    input logic [NCH-1:0] cs_n,
    input logic [NCH-1:0] sclk,
    input logic           done
);
    int unsigned hi_cnt;

    // Count consecutive high cycles of channel 0 chip-select.
    always_ff @(posedge clk) begin
        if (!rst_n)       hi_cnt <= 0;
        else if (cs_n[0]) begin
            if (hi_cnt < GAPC + 1) hi_cnt <= hi_cnt + 1;
        end else          hi_cnt <= 0;
    end

    a_r1_idle_until_ready: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |-> (&cs_n));
    a_r2_sclk_only_selected: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk & cs_n) == '0);
    a_r5_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r5_done_on_cs_rise: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ((&cs_n) && ($past(cs_n) == '0)));
    a_r6_cs_gap: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n[0]) |-> (hi_cnt >= GAPC));
    a_r9_lockstep: assert property (@(posedge clk) disable iff (!rst_n)
        ((cs_n == '0) || (&cs_n)) && ((sclk == '0) || (&sclk)));
endmodule

bind adc_par_reader adc_reader_chk #(.NCH(NCH), .GAPC(GAP_SCLK * CLK_DIV)) u_chk (
    .clk(clk), .rst_n(rst_n), .ready(rel_ready),
    .cs_n(cs_n_o), .sclk(sclk_o), .done(done_o)
);

// File: tb/test_adc_par_reader.sv
module test_adc_par_reader;
    localparam int NCH = 16, DW = 16, CLK_DIV = 4, GAP_SCLK = 2;
    localparam int HALF = CLK_DIV / 2;
    localparam int GAPC = GAP_SCLK * CLK_DIV;
    localparam int NV = 5;
    localparam logic [15:0] VEC [NV] = '{16'hA5C3, 16'h0000, 16'hFFFF, 16'h8001, 16'h1234};

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [NCH-1:0]    miso = '0;
    logic [NCH-1:0]    cs_n_o, sclk_o;
    logic [NCH*DW-1:0] result_o;
    logic              done_o;

    int checks = 0, failures = 0;
    int cyc = 0;
    logic [DW-1:0] adc_word [NCH];
    int mcnt [NCH];
    int rises [NCH];
    logic [NCH-1:0] prev_sclk = '0;
    logic prev_cs0 = 1'b1;
    int sel_cyc = 0, last_rise = 0, first_delay = -1;
    bit per_bad = 0, lock_bad = 0, sc_bad = 0;

    adc_par_reader #(.NCH(NCH), .DW(DW), .CLK_DIV(CLK_DIV), .GAP_SCLK(GAP_SCLK)) i_adc_par_reader (
        .clk(clk), .rst_n(rst_n), .start_i(start), .miso_i(miso),
        .cs_n_o(cs_n_o), .sclk_o(sclk_o), .result_o(result_o), .done_o(done_o)
    );

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // Converter model and pin monitor, evaluated away from the active edge.
    always @(negedge clk) begin
        if (cs_n_o[0] && !prev_cs0) begin end
        if (!cs_n_o[0] && prev_cs0) begin
            sel_cyc = cyc; first_delay = -1; per_bad = 0;
            for (int k = 0; k < NCH; k++) rises[k] = 0;
        end
        for (int k = 0; k < NCH; k++) begin
            if (cs_n_o[k]) mcnt[k] = 0;
            else if (sclk_o[k] && !prev_sclk[k]) begin
                mcnt[k]++;
                if (k == 0) begin
                    if (rises[0] == 0) first_delay = cyc - sel_cyc;
                    else if (cyc - last_rise != CLK_DIV) per_bad = 1;
                    last_rise = cyc;
                end
                rises[k]++;
            end
            miso[k] = adc_word[k][DW - 1 - ((mcnt[k] > DW - 1) ? DW - 1 : mcnt[k])];
        end
        if (!((cs_n_o == '0) || (&cs_n_o)) || !((sclk_o == '0) || (&sclk_o))) lock_bad = 1;
        if ((sclk_o & cs_n_o) != '0) sc_bad = 1;
        prev_sclk = sclk_o;
        prev_cs0 = cs_n_o[0];
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] chan_word(logic [15:0] v, int k);
        logic [3:0] n = 4'(k);
        return (k % 2 == 0) ? v : (v ^ {n, ~n, n, n});
    endfunction

    task automatic load(input logic [15:0] v);
        for (int k = 0; k < NCH; k++) adc_word[k] = chan_word(v, k);
    endtask

    task automatic do_reset();
        start = 1'b0; rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wait_done(input string req);
        int n = 0;
        while (!done_o && n < 400) begin @(negedge clk); n++; end
        chk(done_o, req, "done seen", done_o, 1);
    endtask

    task automatic run_xfer();
        start = 1'b1; @(negedge clk); start = 1'b0;
        wait_done("R5");
    endtask

    task automatic check_results(input string tag);
        for (int k = 0; k < NCH; k++)
            chk(result_o[k*DW +: DW] == adc_word[k], "R4", tag,
                result_o[k*DW +: DW], adc_word[k]);
        chk(rises[0] == DW && rises[NCH-1] == DW, "R3", "sclk periods",
            rises[0], DW);
        chk(!per_bad, "R3", "sclk period length", per_bad, 0);
        chk(first_delay == HALF, "R3", "cs to first rise", first_delay, HALF);
        chk(!lock_bad, "R9", "lockstep outputs", lock_bad, 0);
        chk(!sc_bad, "R2", "sclk high with cs high", sc_bad, 0);
    endtask

    task automatic watch_cs_high(input int n, input string req, input string what);
        bit low_seen = 0;
        repeat (n) begin @(negedge clk); if (cs_n_o != '1) low_seen = 1; end
        chk(!low_seen, req, what, low_seen, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: run did not end, actual hung expected finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        load(VEC[0]);
        // Reset state (R2, R5)
        do_reset();
        @(negedge clk);
        chk(cs_n_o == '1, "R2", "cs after reset", cs_n_o, '1);
        chk(sclk_o == '0, "R2", "sclk after reset", sclk_o, 0);
        chk(!done_o && result_o == '0, "R5", "done/result after reset", result_o, 0);

        // R1: start held through the first 16 edges is ignored
        do_reset();
        start = 1'b1;
        repeat (16) @(negedge clk);
        start = 1'b0;
        watch_cs_high(12, "R1", "start during release fill");

        // R1: start on edge 17 accepted, chip-select low after edge 18
        do_reset();
        start = 1'b1;
        repeat (17) @(negedge clk);
        start = 1'b0;
        chk(cs_n_o == '1, "R1", "cs before accept edge", cs_n_o, '1);
        @(negedge clk);
        chk(cs_n_o == '0, "R1", "cs low after first legal start", cs_n_o, 0);
        wait_done("R1");
        check_results("first xfer");

        // Vector table walk (R3, R4, R5, R9)
        for (int v = 0; v < NV; v++) begin
            load(VEC[v]);
            repeat (GAPC + 4) @(negedge clk);
            run_xfer();
            check_results($sformatf("vector %0d", v));
            @(negedge clk);
            chk(!done_o, "R5", "done one cycle", done_o, 0);
        end

        // R5: results hold after the converters change
        load(16'h5A5A);
        repeat (20) @(negedge clk);
        chk(result_o[DW-1:0] == chan_word(VEC[NV-1], 0), "R5", "result held",
            result_o[DW-1:0], chan_word(VEC[NV-1], 0));

        // R6: start held for GAPC-1 edges after done is ignored
        repeat (GAPC) @(negedge clk);
        run_xfer();
        start = 1'b1;
        repeat (GAPC - 1) @(negedge clk);
        start = 1'b0;
        watch_cs_high(3 * GAPC, "R6", "start inside cs gap");

        // R6: start held through edge GAPC after done is accepted
        load(16'hC0DE);
        run_xfer();
        start = 1'b1;
        repeat (GAPC) @(negedge clk);
        start = 1'b0;
        chk(cs_n_o == '1, "R6", "cs still high at gap end", cs_n_o, '1);
        @(negedge clk);
        chk(cs_n_o == '0, "R6", "start at minimum gap accepted", cs_n_o, 0);
        wait_done("R6");
        check_results("min gap xfer");

        // R7: start during transaction ignored
        load(16'h3C96);
        repeat (GAPC + 2) @(negedge clk);
        start = 1'b1; @(negedge clk); start = 1'b0;
        repeat (20) @(negedge clk);
        start = 1'b1; repeat (3) @(negedge clk); start = 1'b0;
        wait_done("R7");
        check_results("R7 xfer");
        watch_cs_high(3 * GAPC, "R7", "no second xfer");

        // R8: reset mid-transaction
        start = 1'b1; @(negedge clk); start = 1'b0;
        repeat (10) @(negedge clk);
        chk(cs_n_o == '0, "R8", "in transaction before reset", cs_n_o, 0);
        rst_n = 1'b0;
        @(negedge clk);
        chk(cs_n_o == '1 && sclk_o == '0, "R8", "pins idle after reset", cs_n_o, '1);
        chk(result_o == '0 && !done_o, "R8", "results cleared", result_o, 0);
        rst_n = 1'b1;
        start = 1'b1;
        repeat (16) @(negedge clk);
        start = 1'b0;
        watch_cs_high(12, "R8", "release restarted");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule